// File: doc/BRIEF.md
# HDLC Receive Descriptor Chainer

This block takes the byte stream of a receiver that has already found a frame's flags, removed stuffing, filtered addresses and checked the CRC. It stores each accepted frame in a ring of eight buffer descriptors, and each descriptor owns a fixed 16-byte data buffer in internal storage. A descriptor is used only if the host has marked it empty. A frame longer than one buffer continues into the next descriptor of the ring. The descriptor that ends a frame holds the length of the whole frame, the last-buffer mark and the frame status.

The host prepares descriptors through a small write port and reads descriptors and data bytes through combinational read ports. Each time the block writes a descriptor, it also presents that write on output ports for one cycle. The block raises a per-buffer interrupt when a buffer fills. It raises a frame interrupt only after a programmable number of frames has completed. An external timeout strobe can force out a pending frame interrupt early.

Top module: `rx_desc_chain`

## Requirements
- R1: The block stores a byte, or closes a frame, into a descriptor only while that descriptor's empty bit (word bit 16) is set. If the descriptor is not empty, `busyErr` pulses, the block writes no descriptor, it ignores the rest of the frame up to its end or abort, it does not count the frame, and the ring pointer stays where it was.
- R2: When the 16th byte of a buffer is stored, the block writes that descriptor with length 16, last bit (bit 19) clear and empty bit clear. `bufIrq` pulses if the descriptor's interrupt-enable bit (bit 18) is set. The frame then continues in the next descriptor. The next descriptor is index 0 when the wrap bit (bit 17) is set or the index is 7, and the index plus one otherwise.
- R3: Stored bytes appear in arrival order at data address index*16 + offset, where offset counts from 0 within the buffer.
- R4: A byte that arrives after `maxLen` bytes of the frame have already arrived is not stored. The frame is still closed normally, with the too-long bit (bit 21) set.
- R5: On `rxEnd` or `rxAbort`, the block writes the current descriptor as follows. Bits 15:0 hold the number of bytes in the whole frame. Bit 19 is set. Bit 20 is set when `rxEnd` arrives with `rxCrcOk` low. Bit 22 is set on abort. The empty bit is cleared, and the wrap and interrupt-enable bits are kept. The ring pointer then advances as in R2.
- R6: Each closed frame adds to a count. `frameIrq` pulses and the count returns to zero when the count reaches `frameThresh`. A threshold of 0 acts as 1.
- R7: A `timeoutPulse` while the count is nonzero pulses `frameIrq` and clears the count. While the count is zero, the pulse has no effect.
- R8: After reset, all descriptor words and data bytes are zero, the pointer is at index 0, and every strobe output is low. A host write sets the empty, wrap and interrupt-enable bits of the chosen descriptor as given and clears all of its other bits.
- R9: `descWrValid`, `descWrIdx` and `descWrWord` present each descriptor write for exactly one cycle, in the cycle after the event that caused it. Bytes that do not fill a buffer cause no descriptor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| rxEnd | input | 1 | Frame ended this cycle (carries no byte) |
| rxAbort | input | 1 | Frame aborted this cycle (carries no byte) |
| rxCrcOk | input | 1 | CRC result, qualified by rxEnd |
| maxLen | input | 16 | Largest number of bytes stored per frame |
| frameThresh | input | 4 | Frames per frame interrupt (0 acts as 1) |
| timeoutPulse | input | 1 | Forces out a pending frame interrupt |
| hostWrEn | input | 1 | Host descriptor setup strobe |
| hostWrIdx | input | 3 | Descriptor index for setup |
| hostWrEmpty | input | 1 | Empty bit to set up |
| hostWrWrap | input | 1 | Wrap bit to set up |
| hostWrIntEn | input | 1 | Interrupt-enable bit to set up |
| hostRdIdx | input | 3 | Descriptor index to read |
| hostRdDesc | output | 32 | Descriptor word at hostRdIdx |
| hostRdAddr | input | 7 | Data byte address to read |
| hostRdByte | output | 8 | Data byte at hostRdAddr |
| descWrValid | output | 1 | Descriptor write strobe |
| descWrIdx | output | 3 | Index of the written descriptor |
| descWrWord | output | 32 | Word written |
| busyErr | output | 1 | Non-empty descriptor met; frame dropped |
| bufIrq | output | 1 | Buffer-full interrupt |
| frameIrq | output | 1 | Frame threshold or timeout interrupt |

## Verification
Each input event is one cycle of the byte, end, abort or timeout inputs. Every result of that event is registered once: the descriptor write, `busyErr`, `bufIrq` and `frameIrq` all show in the cycle that follows the consuming edge, and they last exactly that one cycle. The bench drives each event on a falling edge and samples all strobe outputs on the next falling edge. That is half a cycle after the edge that consumed the event, so every check looks at the single cycle in which its result is due. The stored bytes and descriptor words are read back combinationally through the host read ports once the bench stops driving, so those reads carry no latency.

// File: rtl/rxchain_pkg.sv
package rxchain_pkg;
  parameter int DESC_NUM  = 8;
  parameter int BUF_BYTES = 16;
  parameter int LEN_W     = 16;
  localparam int IDX_W    = $clog2(DESC_NUM);
  localparam int OFF_W    = $clog2(BUF_BYTES);
  localparam int ADDR_W   = IDX_W + OFF_W;

  // descriptor word layout
  localparam int BIT_EMPTY   = 16;
  localparam int BIT_WRAP    = 17;
  localparam int BIT_INTEN   = 18;
  localparam int BIT_LAST    = 19;
  localparam int BIT_CRCERR  = 20;
  localparam int BIT_TOOLONG = 21;
  localparam int BIT_ABORT   = 22;

  typedef struct packed {
    logic             dataWe;
    logic [IDX_W-1:0] dataIdx;
    logic [OFF_W-1:0] dataOff;
    logic [7:0]       dataByte;
    logic             descWe;
    logic [IDX_W-1:0] descIdx;
    logic [LEN_W-1:0] descLen;
    logic             descLast;
    logic             descCrcErr;
    logic             descTooLong;
    logic             descAbort;
  } strobe_t;
endpackage

// File: rtl/rxchain_ctrl.sv
module rxchain_ctrl
  import rxchain_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxEnd,
  input  logic             rxAbort,
  input  logic             rxCrcOk,
  input  logic [LEN_W-1:0] maxLen,
  input  logic [THR_W-1:0] frameThresh,
  input  logic             timeoutPulse,
  input  logic             curEmpty,
  input  logic             curWrap,
  input  logic             curIntEn,
  output logic [IDX_W-1:0] curIdx,
  output strobe_t          stb,
  output logic             busyErr,
  output logic             bufIrq,
  output logic             frameIrq
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DROP} state_t;

  state_t           state, stateN;
  logic             haveBd, haveBdN;
  logic [IDX_W-1:0] idxN, advIdx;
  logic [OFF_W-1:0] byteOff, offN;
  logic [LEN_W-1:0] frameLen, lenN, lenInc;
  logic             tooLong, tlN;
  logic             busyN, bufIrqN, frameDone;
  logic             isByte, isClose, bdOk;
  logic [THR_W-1:0] frameCnt, cntN;
  logic [THR_W:0]   total, effThresh;
  logic             frameIrqN;

  assign isByte  = rxValid & ~rxEnd & ~rxAbort;
  assign isClose = rxEnd | rxAbort;
  assign bdOk    = haveBd | curEmpty;
  assign lenInc  = (&frameLen) ? frameLen : frameLen + 1'b1;
  assign advIdx  = (curWrap || curIdx == IDX_W'(DESC_NUM - 1)) ? '0 : curIdx + 1'b1;

  always_comb begin
    stb       = '0;
    stateN    = state;
    haveBdN   = haveBd;
    idxN      = curIdx;
    offN      = byteOff;
    lenN      = frameLen;
    tlN       = tooLong;
    busyN     = 1'b0;
    bufIrqN   = 1'b0;
    frameDone = 1'b0;
    case (state)
      ST_IDLE, ST_RUN: begin
        if (isByte) begin
          if (!bdOk) begin
            busyN   = 1'b1;
            stateN  = ST_DROP;
            haveBdN = 1'b0;
            offN    = '0;
            lenN    = '0;
            tlN     = 1'b0;
          end else begin
            stateN  = ST_RUN;
            haveBdN = 1'b1;
            lenN    = lenInc;
            if (frameLen >= maxLen) begin
              tlN = 1'b1;
            end else begin
              stb.dataWe   = 1'b1;
              stb.dataIdx  = curIdx;
              stb.dataOff  = byteOff;
              stb.dataByte = rxByte;
              if (byteOff == OFF_W'(BUF_BYTES - 1)) begin
                stb.descWe  = 1'b1;
                stb.descIdx = curIdx;
                stb.descLen = LEN_W'(BUF_BYTES);
                bufIrqN     = curIntEn;
                idxN        = advIdx;
                haveBdN     = 1'b0;
                offN        = '0;
              end else begin
                offN = byteOff + 1'b1;
              end
            end
          end
        end else if (isClose && state == ST_RUN) begin
          if (bdOk) begin
            stb.descWe      = 1'b1;
            stb.descIdx     = curIdx;
            stb.descLen     = frameLen;
            stb.descLast    = 1'b1;
            stb.descCrcErr  = ~rxAbort & ~rxCrcOk;
            stb.descAbort   = rxAbort;
            stb.descTooLong = tooLong;
            idxN            = advIdx;
            frameDone       = 1'b1;
          end else begin
            busyN = 1'b1;
          end
          stateN  = ST_IDLE;
          haveBdN = 1'b0;
          offN    = '0;
          lenN    = '0;
          tlN     = 1'b0;
        end
      end
      ST_DROP: begin
        if (isClose) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  // received-frame batching
  always_comb begin
    total     = {1'b0, frameCnt} + (THR_W+1)'(frameDone);
    effThresh = {1'b0, (frameThresh == '0) ? THR_W'(1) : frameThresh};
    frameIrqN = 1'b0;
    cntN      = total[THR_W-1:0];
    if ((frameDone && total >= effThresh) || (timeoutPulse && total != '0)) begin
      frameIrqN = 1'b1;
      cntN      = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      haveBd   <= 1'b0;
      curIdx   <= '0;
      byteOff  <= '0;
      frameLen <= '0;
      tooLong  <= 1'b0;
      frameCnt <= '0;
      busyErr  <= 1'b0;
      bufIrq   <= 1'b0;
      frameIrq <= 1'b0;
    end else begin
      state    <= stateN;
      haveBd   <= haveBdN;
      curIdx   <= idxN;
      byteOff  <= offN;
      frameLen <= lenN;
      tooLong  <= tlN;
      frameCnt <= cntN;
      busyErr  <= busyN;
      bufIrq   <= bufIrqN;
      frameIrq <= frameIrqN;
    end
  end

  AST_STORE_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWe |-> (frameLen < maxLen)); // R4
  AST_FRAME_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    frameIrq |-> (frameCnt == '0)); // R6
  AST_TIMEOUT_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPulse && frameCnt == '0 && !frameDone) |=> !frameIrq); // R7
  AST_BUSY_NO_DESC: assert property (@(posedge clk) disable iff (!rstN)
    busyN |-> !stb.descWe); // R1
endmodule

// File: rtl/rxchain_dpath.sv
module rxchain_dpath
  import rxchain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  curIdx,
  output logic              curEmpty,
  output logic              curWrap,
  output logic              curIntEn,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic              hostWrEmpty,
  input  logic              hostWrWrap,
  input  logic              hostWrIntEn,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [31:0]       hostRdDesc,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [7:0]        hostRdByte,
  output logic              descWrValid,
  output logic [IDX_W-1:0]  descWrIdx,
  output logic [31:0]       descWrWord
);
  localparam int DATA_DEPTH = DESC_NUM * BUF_BYTES;

  logic [31:0] descRam [DESC_NUM];
  logic [7:0]  dataRam [DATA_DEPTH];
  logic [31:0] oldWord, blockWord, hostWord;

  assign curEmpty   = descRam[curIdx][BIT_EMPTY];
  assign curWrap    = descRam[curIdx][BIT_WRAP];
  assign curIntEn   = descRam[curIdx][BIT_INTEN];
  assign hostRdDesc = descRam[hostRdIdx];
  assign hostRdByte = dataRam[hostRdAddr];
  assign oldWord    = descRam[stb.descIdx];

  always_comb begin
    blockWord               = '0;
    blockWord[LEN_W-1:0]    = stb.descLen;
    blockWord[BIT_WRAP]     = oldWord[BIT_WRAP];
    blockWord[BIT_INTEN]    = oldWord[BIT_INTEN];
    blockWord[BIT_LAST]     = stb.descLast;
    blockWord[BIT_CRCERR]   = stb.descCrcErr;
    blockWord[BIT_TOOLONG]  = stb.descTooLong;
    blockWord[BIT_ABORT]    = stb.descAbort;
    hostWord                = '0;
    hostWord[BIT_EMPTY]     = hostWrEmpty;
    hostWord[BIT_WRAP]      = hostWrWrap;
    hostWord[BIT_INTEN]     = hostWrIntEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_NUM; i++) descRam[i] <= '0;
      for (int j = 0; j < DATA_DEPTH; j++) dataRam[j] <= '0;
      descWrValid <= 1'b0;
      descWrIdx   <= '0;
      descWrWord  <= '0;
    end else begin
      if (hostWrEn) descRam[hostWrIdx] <= hostWord;
      if (stb.descWe) descRam[stb.descIdx] <= blockWord;
      if (stb.dataWe) dataRam[{stb.dataIdx, stb.dataOff}] <= stb.dataByte;
      descWrValid <= stb.descWe;
      descWrIdx   <= stb.descIdx;
      descWrWord  <= blockWord;
    end
  end

  AST_WRITE_TO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.descWe |-> descRam[stb.descIdx][BIT_EMPTY]); // R1
  AST_DATA_TO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWe |-> descRam[stb.dataIdx][BIT_EMPTY]); // R1
  AST_EMPTY_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    descWrValid |-> !descWrWord[BIT_EMPTY]); // R5
  AST_PARTIAL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (descWrValid && !descWrWord[BIT_LAST]) |-> (descWrWord[LEN_W-1:0] == LEN_W'(BUF_BYTES))); // R2
endmodule

// File: rtl/rx_desc_chain.sv
module rx_desc_chain
  import rxchain_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxEnd,
  input  logic              rxAbort,
  input  logic              rxCrcOk,
  input  logic [LEN_W-1:0]  maxLen,
  input  logic [THR_W-1:0]  frameThresh,
  input  logic              timeoutPulse,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrIdx,
  input  logic              hostWrEmpty,
  input  logic              hostWrWrap,
  input  logic              hostWrIntEn,
  input  logic [IDX_W-1:0]  hostRdIdx,
  output logic [31:0]       hostRdDesc,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [7:0]        hostRdByte,
  output logic              descWrValid,
  output logic [IDX_W-1:0]  descWrIdx,
  output logic [31:0]       descWrWord,
  output logic              busyErr,
  output logic              bufIrq,
  output logic              frameIrq
);
  strobe_t          stb;
  logic [IDX_W-1:0] curIdx;
  logic             curEmpty, curWrap, curIntEn;

  rxchain_ctrl #(.THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .rxEnd(rxEnd),
    .rxAbort(rxAbort), .rxCrcOk(rxCrcOk), .maxLen(maxLen), .frameThresh(frameThresh),
    .timeoutPulse(timeoutPulse), .curEmpty(curEmpty), .curWrap(curWrap),
    .curIntEn(curIntEn), .curIdx(curIdx), .stb(stb), .busyErr(busyErr),
    .bufIrq(bufIrq), .frameIrq(frameIrq)
  );

  rxchain_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .curIdx(curIdx), .curEmpty(curEmpty),
    .curWrap(curWrap), .curIntEn(curIntEn), .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx),
    .hostWrEmpty(hostWrEmpty), .hostWrWrap(hostWrWrap), .hostWrIntEn(hostWrIntEn),
    .hostRdIdx(hostRdIdx), .hostRdDesc(hostRdDesc), .hostRdAddr(hostRdAddr),
    .hostRdByte(hostRdByte), .descWrValid(descWrValid), .descWrIdx(descWrIdx),
    .descWrWord(descWrWord)
  );
endmodule

// File: tb/rx_desc_chain_bench.sv
module rx_desc_chain_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rxValid, rxEnd, rxAbort, rxCrcOk, timeoutPulse;
  logic [7:0]  rxByte;
  logic [15:0] maxLen;
  logic [3:0]  frameThresh;
  logic        hostWrEn, hostWrEmpty, hostWrWrap, hostWrIntEn;
  logic [2:0]  hostWrIdx, hostRdIdx, descWrIdx;
  logic [31:0] hostRdDesc, descWrWord;
  logic [6:0]  hostRdAddr;
  logic [7:0]  hostRdByte;
  logic        descWrValid, busyErr, bufIrq, frameIrq;

  int compared = 0;
  int mismatched = 0;
  logic        sWrV, sBusy, sBuf, sFrame;
  logic [2:0]  sWrIdx;
  logic [31:0] sWrWord;

  always #10 clk = ~clk;

  rx_desc_chain u_rx_desc_chain (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .rxEnd(rxEnd),
    .rxAbort(rxAbort), .rxCrcOk(rxCrcOk), .maxLen(maxLen), .frameThresh(frameThresh),
    .timeoutPulse(timeoutPulse), .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx),
    .hostWrEmpty(hostWrEmpty), .hostWrWrap(hostWrWrap), .hostWrIntEn(hostWrIntEn),
    .hostRdIdx(hostRdIdx), .hostRdDesc(hostRdDesc), .hostRdAddr(hostRdAddr),
    .hostRdByte(hostRdByte), .descWrValid(descWrValid), .descWrIdx(descWrIdx),
    .descWrWord(descWrWord), .busyErr(busyErr), .bufIrq(bufIrq), .frameIrq(frameIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic snap();
    sWrV = descWrValid; sWrIdx = descWrIdx; sWrWord = descWrWord;
    sBusy = busyErr; sBuf = bufIrq; sFrame = frameIrq;
  endtask

  // one input event, then sample its registered result half a cycle later
  task automatic ev(input logic v, input logic [7:0] b, input logic e, input logic a, input logic c);
    rxValid = v; rxByte = b; rxEnd = e; rxAbort = a; rxCrcOk = c;
    @(negedge clk);
    snap();
    rxValid = 0; rxEnd = 0; rxAbort = 0; rxCrcOk = 0;
  endtask

  task automatic sendBytes(input logic [7:0] first, input int n, output logic anyWr);
    anyWr = 0;
    for (int k = 0; k < n; k++) begin
      ev(1, first + 8'(k), 0, 0, 0);
      anyWr = anyWr | sWrV;
    end
  endtask

  task automatic hostWr(input logic [2:0] idx, input logic e, input logic w, input logic i);
    hostWrEn = 1; hostWrIdx = idx; hostWrEmpty = e; hostWrWrap = w; hostWrIntEn = i;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic rdDesc(input logic [2:0] idx, output logic [31:0] w);
    hostRdIdx = idx; #1; w = hostRdDesc;
  endtask

  task automatic rdByte(input logic [6:0] a, output logic [7:0] b);
    hostRdAddr = a; #1; b = hostRdByte;
  endtask

  task automatic testReset();
    logic [31:0] w; logic [7:0] b;
    rdDesc(0, w); chk("R8 desc0 after reset", w, 0);
    rdByte(0, b); chk("R8 data0 after reset", {24'd0, b}, 0);
    chk("R8 strobes low after reset", {28'd0, descWrValid, busyErr, bufIrq, frameIrq}, 0);
    hostWr(3, 1, 1, 0);
    rdDesc(3, w); chk("R8 host setup word", w, 32'h0003_0000);
    hostWr(3, 0, 0, 0);
  endtask

  task automatic testShortFrame();
    logic anyWr; logic [31:0] w; logic [7:0] b;
    frameThresh = 1;
    hostWr(0, 1, 0, 1);
    sendBytes(8'h10, 5, anyWr);
    chk("R9 no descriptor write mid-buffer", {31'd0, anyWr}, 0);
    ev(0, 0, 1, 0, 1);
    chk("R9 final write strobe", {31'd0, sWrV}, 1);
    chk("R5 final write index", {29'd0, sWrIdx}, 0);
    chk("R5 final word short frame", sWrWord, 32'h000C_0005);
    chk("R6 threshold 1 irq", {31'd0, sFrame}, 1);
    ev(0, 0, 0, 0, 0);
    chk("R9 strobe lasts one cycle", {31'd0, sWrV}, 0);
    rdByte(4, b); chk("R3 byte order desc0 off4", {24'd0, b}, 32'h14);
    rdDesc(0, w); chk("R5 stored word desc0", w, 32'h000C_0005);
  endtask

  task automatic testSpill();
    logic anyWr; logic [7:0] b;
    hostWr(1, 1, 0, 1);
    hostWr(2, 1, 0, 0);
    sendBytes(8'h20, 15, anyWr);
    ev(1, 8'h2F, 0, 0, 0);
    chk("R2 fill write index", {29'd0, sWrIdx}, 1);
    chk("R2 fill word", sWrWord, 32'h0004_0010);
    chk("R2 buffer irq", {31'd0, sBuf}, 1);
    sendBytes(8'h30, 4, anyWr);
    ev(0, 0, 1, 0, 0);
    chk("R5 spill final index", {29'd0, sWrIdx}, 2);
    chk("R5 whole-frame length with crc error", sWrWord, 32'h0018_0014);
    rdByte(7'd35, b); chk("R3 spilled byte desc2 off3", {24'd0, b}, 32'h33);
  endtask

  task automatic testBusyAndTooLong();
    logic anyWr; logic [31:0] w; logic [7:0] b;
    frameThresh = 3;
    ev(1, 8'h99, 0, 0, 0);
    chk("R1 busy error on full descriptor", {31'd0, sBusy}, 1);
    chk("R1 no write on busy", {31'd0, sWrV}, 0);
    sendBytes(8'h90, 3, anyWr);
    ev(0, 0, 1, 0, 1);
    chk("R1 dropped frame: no write, no irq", {30'd0, sWrV | anyWr, sFrame}, 0);
    rdDesc(3, w); chk("R1 busy descriptor untouched", w, 0);
    hostWr(3, 1, 1, 0);
    maxLen = 4;
    sendBytes(8'hA0, 6, anyWr);
    ev(0, 0, 1, 0, 1);
    chk("R1 pointer held after drop", {29'd0, sWrIdx}, 3);
    chk("R4 too-long final word", sWrWord, 32'h002A_0006);
    chk("R6 below threshold no irq", {31'd0, sFrame}, 0);
    rdByte(7'd51, b); chk("R4 last allowed byte stored", {24'd0, b}, 32'hA3);
    rdByte(7'd52, b); chk("R4 byte past max not stored", {24'd0, b}, 0);
    maxLen = 100;
  endtask

  task automatic testWrapAbortTimeout();
    logic anyWr;
    hostWr(0, 1, 0, 0);
    sendBytes(8'h55, 2, anyWr);
    ev(0, 0, 0, 1, 0);
    chk("R2 wrap bit returns to desc0", {29'd0, sWrIdx}, 0);
    chk("R5 abort word", sWrWord, 32'h0048_0002);
    chk("R6 count 2 of 3 no irq", {31'd0, sFrame}, 0);
    timeoutPulse = 1; @(negedge clk); snap(); timeoutPulse = 0;
    chk("R7 timeout flushes pending count", {31'd0, sFrame}, 1);
    timeoutPulse = 1; @(negedge clk); snap(); timeoutPulse = 0;
    chk("R7 timeout with zero count quiet", {31'd0, sFrame}, 0);
  endtask

  task automatic testThreshold();
    logic anyWr;
    frameThresh = 2;
    hostWr(1, 1, 0, 0);
    hostWr(2, 1, 0, 0);
    sendBytes(8'h61, 3, anyWr);
    ev(0, 0, 1, 0, 1);
    chk("R5 next frame in desc1", sWrWord, 32'h0008_0003);
    chk("R6 first of two no irq", {31'd0, sFrame}, 0);
    sendBytes(8'h71, 1, anyWr);
    ev(0, 0, 1, 0, 1);
    chk("R6 second of two irq", {31'd0, sFrame}, 1);
  endtask

  initial begin
    rstN = 0; rxValid = 0; rxByte = 0; rxEnd = 0; rxAbort = 0; rxCrcOk = 0;
    maxLen = 100; frameThresh = 1; timeoutPulse = 0;
    hostWrEn = 0; hostWrIdx = 0; hostWrEmpty = 0; hostWrWrap = 0; hostWrIntEn = 0;
    hostRdIdx = 0; hostRdAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testShortFrame();
    testSpill();
    testBusyAndTooLong();
    testWrapAbortTimeout();
    testThreshold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule